// File: doc/BRIEF.md
# Handshaked Shift-Register Packet Transfer Engine

This block carries packet bytes in both directions between a host processor and a peripheral controller through a single 8-bit shift register. The host paces each byte with two active-low lines: transfer-active and host-acknowledge. The block answers on one active-low data-request line. A direction input picks the direction of every byte. When the host is sending, each handshake step copies the shift register into a capture buffer. When the host is receiving, each step loads the next queued response byte into the shift register.

When transfer-active is released, the block closes the host packet. It pulses a packet-done strobe with the captured length and empties the capture buffer. Every byte step, every packet end and every idle acknowledge toggle requests a shift-register interrupt. That interrupt is issued after a configurable number of clock cycles. It is issued on the next cycle instead when the port direction register holds all ones. The peripheral side queues a response by writing bytes into a 16-entry response memory and then committing a length.

All handshake inputs are taken as synchronous to `clk`, and the block looks at them on every cycle.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, data-request reads 0 (asserted), the shift register is 0x00, the port direction register is 0xFF, the capture count is 0, and no strobe is active.
- R2: While transfer-active is low and direction is 1 (host sending), each cycle in which the {acknowledge, transfer-active} pair differs from its value on the previous cycle stores the shift register into the next capture slot and increments the capture count.
- R3: Once the capture count equals OUT_DEPTH, further sending steps store nothing, leave the count unchanged and request no interrupt.
- R4: While transfer-active is low and direction is 0 (host receiving), each pair change loads the next unread response byte into the shift register. When no response byte remains, a pair change leaves the shift register alone and requests no interrupt.
- R5: The step that delivers the final response byte drives data-request to 1.
- R6: With transfer-active high on both this cycle and the previous one, a change of acknowledge makes data-request equal the new acknowledge level and requests an interrupt.
- R7: On the first cycle with transfer-active high after it was low, the block requests an interrupt and clears the capture count. If the count was nonzero, it also pulses packet-done for one cycle with packet length equal to that count.
- R8: With transfer-active high and no acknowledge toggle, data-request is driven to 0 whenever unread response bytes remain.
- R9: With a direction register other than 0xFF, the interrupt pulse appears DELAY_CYC cycles later than a direct one. A new request while waiting restarts the full delay.
- R10: With the direction register at 0xFF, an interrupt request produces a one-cycle pulse on the clock edge that registers it.
- R11: A response commit sets the response length (clamped to RSP_DEPTH) and rewinds the read position to the first byte.
- R12: A host write to the shift register is visible on the shift register output after the next clock edge, unless a response load happens in that same cycle, in which case the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_n_i | input | 1 | Transfer-active from host, active low |
| ack_n_i | input | 1 | Host acknowledge, active low |
| req_n_o | output | 1 | Data-request to host, active low |
| dir_send_i | input | 1 | 1: host sending, 0: host receiving |
| sr_wr_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Host write data for the shift register |
| sr_o | output | 8 | Shift register contents |
| pdir_wr_i | input | 1 | Write strobe for the port direction register |
| pdir_wdata_i | input | 8 | Port direction register write data |
| pdir_o | output | 8 | Port direction register contents |
| rsp_wr_i | input | 1 | Response memory byte write strobe |
| rsp_waddr_i | input | RSP_AW | Response memory byte address |
| rsp_wdata_i | input | 8 | Response memory byte data |
| rsp_commit_i | input | 1 | Commit response length and rewind |
| rsp_len_i | input | RSP_LW | Response length to commit |
| cap_raddr_i | input | CAP_AW | Capture buffer read address |
| cap_rdata_o | output | 8 | Capture buffer read data |
| cap_count_o | output | CAP_LW | Bytes captured in the current packet |
| pkt_done_o | output | 1 | One-cycle packet-done strobe |
| pkt_len_o | output | CAP_LW | Length of the packet that just ended |
| sr_irq_o | output | 1 | One-cycle shift-register interrupt pulse |

## Verification
The bench works the edges of the handshake. It checks the first step after transfer-active falls, which must already move a byte; a design that waited for acknowledge would lose the first byte. It checks the step that empties the response queue, which must release data-request; a design that missed this would leave the host polling for data that never comes. It also checks a step made with nothing queued, which must move nothing and raise no interrupt. It fills the capture buffer and steps once more: an overflowing design would wrap the count. It ends a packet with zero bytes, which must interrupt without a packet-done strobe. Finally it measures the exact delay of the interrupt and its restart, which catches off-by-one counters and a counter that ignores a retrigger.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic capture;
    logic load;
    logic pkt_end;
    logic irq_req;
  } hs_act_t;
endpackage

// File: rtl/hs_handshake_dec.sv
module hs_handshake_dec
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    act_n,
  input  logic    ack_n,
  input  logic    dir_send,
  input  logic    rsp_pending,
  input  logic    rsp_last,
  input  logic    cap_full,
  output hs_act_t act,
  output logic    req_n
);
  logic last_act_q, last_ack_q, req_q;
  logic req_d, pair_chg, ack_chg;

  assign pair_chg = (act_n != last_act_q) || (ack_n != last_ack_q);
  assign ack_chg  = (ack_n != last_ack_q);

  always_comb begin
    act   = '0;
    req_d = req_q;
    if (!act_n) begin
      if (dir_send) begin
        if (pair_chg && !cap_full) begin
          act.capture = 1'b1;
          act.irq_req = 1'b1;
        end
      end else if (rsp_pending && pair_chg) begin
        act.load    = 1'b1;
        act.irq_req = 1'b1;
        if (rsp_last) req_d = 1'b1;
      end
    end else if (last_act_q && ack_chg) begin
      req_d       = ack_n;
      act.irq_req = 1'b1;
    end else begin
      if (!last_act_q) begin
        act.pkt_end = 1'b1;
        act.irq_req = 1'b1;
      end
      if (rsp_pending) req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_act_q <= 1'b0;
      last_ack_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      last_act_q <= act_n;
      last_ack_q <= ack_n;
      req_q      <= req_d;
    end
  end

  assign req_n = req_q;

  assert_sync_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n && last_act_q && ack_chg) |=> (req_n == $past(ack_n)));

  assert_last_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act.load && rsp_last) |=> req_n);

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.pkt_end && (act.capture || act.load)));
endmodule

// File: rtl/hs_cap_buf.sv
module hs_cap_buf
  import hs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] din,
  input  logic              flush,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata,
  output logic [LW-1:0]     count,
  output logic              full
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [LW-1:0]     cnt_q, cnt_d;

  assign full = (cnt_q == LW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (flush)               cnt_d = '0;
    else if (capture && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = capture && !full && !flush && (cnt_q == LW'(i));
    always_ff @(posedge clk) begin
      if (wen) mem_q[i] <= din;
    end
  end

  assign rdata = mem_q[raddr];
  assign count = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !full && !flush) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/hs_rsp_buf.sv
module hs_rsp_buf
  import hs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              commit,
  input  logic [LW-1:0]     commit_len,
  input  logic              advance,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              pending,
  output logic              last
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [LW-1:0]     len_q, len_d, idx_q, idx_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && (waddr == AW'(i))) mem_q[i] <= wdata;
    end
  end

  assign pending  = (idx_q < len_q);
  assign last     = pending && ((idx_q + 1'b1) == len_q);
  assign cur_byte = mem_q[idx_q[AW-1:0]];

  always_comb begin
    len_d = len_q;
    idx_d = idx_q;
    if (commit) begin
      len_d = (commit_len > LW'(DEPTH)) ? LW'(DEPTH) : commit_len;
      idx_d = '0;
    end else if (advance && pending) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
    end else begin
      len_q <= len_d;
      idx_q <= idx_d;
    end
  end

  assert_commit_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (idx_q == '0));

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_q || $past(commit) == 1'b0);
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DELAY_CYC = 37500,
  localparam int CW = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic direct,
  output logic pulse
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pls_q, pls_d;

  always_comb begin
    cnt_d = cnt_q;
    pls_d = 1'b0;
    if (req) begin
      if (direct) begin
        pls_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = CW'(DELAY_CYC);
      end
    end else if (cnt_q == CW'(1)) begin
      pls_d = 1'b1;
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign pulse = pls_q;

  assert_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && direct) |=> pulse);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !direct) |=> !pulse);
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
  import hs_pkg::*;
#(
  parameter int CAP_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int DELAY_CYC = 37500,
  localparam int CAP_AW = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1,
  localparam int CAP_LW = $clog2(CAP_DEPTH + 1),
  localparam int RSP_AW = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1,
  localparam int RSP_LW = $clog2(RSP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_n_i,
  input  logic              ack_n_i,
  output logic              req_n_o,
  input  logic              dir_send_i,
  input  logic              sr_wr_i,
  input  logic [BYTE_W-1:0] sr_wdata_i,
  output logic [BYTE_W-1:0] sr_o,
  input  logic              pdir_wr_i,
  input  logic [BYTE_W-1:0] pdir_wdata_i,
  output logic [BYTE_W-1:0] pdir_o,
  input  logic              rsp_wr_i,
  input  logic [RSP_AW-1:0] rsp_waddr_i,
  input  logic [BYTE_W-1:0] rsp_wdata_i,
  input  logic              rsp_commit_i,
  input  logic [RSP_LW-1:0] rsp_len_i,
  input  logic [CAP_AW-1:0] cap_raddr_i,
  output logic [BYTE_W-1:0] cap_rdata_o,
  output logic [CAP_LW-1:0] cap_count_o,
  output logic              pkt_done_o,
  output logic [CAP_LW-1:0] pkt_len_o,
  output logic              sr_irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  hs_act_t           act;
  logic              rsp_pending, rsp_last, cap_full;
  logic [BYTE_W-1:0] rsp_byte;
  logic [BYTE_W-1:0] sr_q, sr_d, pdir_q, pdir_d;
  logic              done_q, done_d;
  logic [CAP_LW-1:0] plen_q, plen_d, cap_cnt;

  hs_handshake_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .act_n      (act_n_i),
    .ack_n      (ack_n_i),
    .dir_send   (dir_send_i),
    .rsp_pending(rsp_pending),
    .rsp_last   (rsp_last),
    .cap_full   (cap_full),
    .act        (act),
    .req_n      (req_n_o)
  );

  hs_cap_buf #(.DEPTH(CAP_DEPTH)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .capture(act.capture),
    .din    (sr_q),
    .flush  (act.pkt_end),
    .raddr  (cap_raddr_i),
    .rdata  (cap_rdata_o),
    .count  (cap_cnt),
    .full   (cap_full)
  );

  hs_rsp_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (rsp_wr_i),
    .waddr     (rsp_waddr_i),
    .wdata     (rsp_wdata_i),
    .commit    (rsp_commit_i),
    .commit_len(rsp_len_i),
    .advance   (act.load),
    .cur_byte  (rsp_byte),
    .pending   (rsp_pending),
    .last      (rsp_last)
  );

  hs_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_i),
    .req   (act.irq_req),
    .direct(pdir_q == '1),
    .pulse (sr_irq_o)
  );

  always_comb begin
    sr_d   = sr_q;
    pdir_d = pdir_q;
    done_d = 1'b0;
    plen_d = plen_q;
    if (act.load)     sr_d = rsp_byte;
    else if (sr_wr_i) sr_d = sr_wdata_i;
    if (pdir_wr_i)    pdir_d = pdir_wdata_i;
    if (act.pkt_end) begin
      done_d = (cap_cnt != '0);
      plen_d = cap_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sr_q   <= '0;
      pdir_q <= '1;
      done_q <= 1'b0;
      plen_q <= '0;
    end else begin
      sr_q   <= sr_d;
      pdir_q <= pdir_d;
      done_q <= done_d;
      plen_q <= plen_d;
    end
  end

  assign sr_o        = sr_q;
  assign pdir_o      = pdir_q;
  assign cap_count_o = cap_cnt;
  assign pkt_done_o  = done_q;
  assign pkt_len_o   = plen_q;

  assert_end_clear_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    act.pkt_end |=> (cap_count_o == '0));

  assert_done_len_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    pkt_done_o |-> (pkt_len_o != '0));
endmodule

// File: tb/sim_hs_xfer_engine.sv
`timescale 1ns/1ps
module sim_hs_xfer_engine;
  localparam int CAPD = 4;
  localparam int RSPD = 16;
  localparam int DLY  = 20;
  localparam int CLW  = $clog2(CAPD + 1);
  localparam int CAW  = $clog2(CAPD);
  localparam int RAW  = $clog2(RSPD);
  localparam int RLW  = $clog2(RSPD + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, act_n, ack_n, dir_send, sr_wr, pdir_wr, rsp_wr, rsp_commit;
  logic [7:0] sr_wdata, pdir_wdata, rsp_wdata;
  logic [RAW-1:0] rsp_waddr;
  logic [RLW-1:0] rsp_len;
  logic [CAW-1:0] cap_raddr;
  logic req_n, pkt_done, sr_irq;
  logic [7:0] sr, pdir, cap_rdata;
  logic [CLW-1:0] cap_count, pkt_len;

  hs_xfer_engine #(.CAP_DEPTH(CAPD), .RSP_DEPTH(RSPD), .DELAY_CYC(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .act_n_i(act_n), .ack_n_i(ack_n), .req_n_o(req_n),
    .dir_send_i(dir_send), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .sr_o(sr),
    .pdir_wr_i(pdir_wr), .pdir_wdata_i(pdir_wdata), .pdir_o(pdir),
    .rsp_wr_i(rsp_wr), .rsp_waddr_i(rsp_waddr), .rsp_wdata_i(rsp_wdata),
    .rsp_commit_i(rsp_commit), .rsp_len_i(rsp_len), .cap_raddr_i(cap_raddr),
    .cap_rdata_o(cap_rdata), .cap_count_o(cap_count), .pkt_done_o(pkt_done),
    .pkt_len_o(pkt_len), .sr_irq_o(sr_irq)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // fields: act ack dir srw srd[8] req cnt[5] pkt len[5] irq  (25 bits)
  localparam int NV = 9;
  localparam logic [24:0] VECS [NV] = '{
    {1'b1,1'b0,1'b1,1'b1,8'hA1, 1'b0,5'd0,1'b0,5'd0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'h00, 1'b1,5'd0,1'b0,5'd0,1'b1},
    {1'b0,1'b1,1'b1,1'b0,8'h00, 1'b1,5'd1,1'b0,5'd0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,8'hB2, 1'b1,5'd1,1'b0,5'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,8'h00, 1'b1,5'd2,1'b0,5'd0,1'b1},
    {1'b0,1'b0,1'b1,1'b1,8'hC3, 1'b1,5'd2,1'b0,5'd0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,8'h00, 1'b1,5'd3,1'b0,5'd0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'h00, 1'b1,5'd0,1'b1,5'd3,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'h00, 1'b1,5'd0,1'b0,5'd0,1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic measure_irq(input string tag, input int exp);
    int seen = 0;
    for (int k = 1; k <= 100; k++) begin
      step();
      if (sr_irq) begin
        seen = k;
        break;
      end
    end
    chk(tag, seen, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; act_n = 1'b1; ack_n = 1'b1; dir_send = 1'b1;
    sr_wr = 1'b0; sr_wdata = '0; pdir_wr = 1'b0; pdir_wdata = '0;
    rsp_wr = 1'b0; rsp_waddr = '0; rsp_wdata = '0; rsp_commit = 1'b0;
    rsp_len = '0; cap_raddr = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 req_n", req_n, 0);
    chk("R1 sr", sr, 8'h00);
    chk("R1 pdir", pdir, 8'hFF);
    chk("R1 count", cap_count, 0);
    chk("R1 strobes", {pkt_done, sr_irq}, 0);
    rst_n = 1'b1;
    repeat (6) step();

    // vector table: sync toggles then a 3-byte host packet (R2 R6 R7 R10 R12)
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VECS[i];
      act_n = v[24]; ack_n = v[23]; dir_send = v[22];
      sr_wr = v[21]; sr_wdata = v[20:13];
      step();
      sr_wr = 1'b0;
      chk($sformatf("R6 req_n row %0d", i), req_n, int'(v[12]));
      chk($sformatf("R2 count row %0d", i), cap_count, int'(v[11:7]));
      chk($sformatf("R7 pkt_done row %0d", i), pkt_done, int'(v[6]));
      if (v[6]) chk($sformatf("R7 pkt_len row %0d", i), pkt_len, int'(v[5:1]));
      chk($sformatf("R10 irq row %0d", i), sr_irq, int'(v[0]));
    end

    // R2 captured contents
    cap_raddr = 2'd0; #1 chk("R2 slot0", cap_rdata, 8'hA1);
    cap_raddr = 2'd1; #1 chk("R2 slot1", cap_rdata, 8'hB2);
    cap_raddr = 2'd2; #1 chk("R2 slot2", cap_rdata, 8'hC3);

    // R11 queue a response of 3 bytes
    for (int a = 0; a < 3; a++) begin
      rsp_wr = 1'b1; rsp_waddr = RAW'(a); rsp_wdata = 8'(8'h11 * (a + 1));
      step();
    end
    rsp_wr = 1'b0;
    rsp_commit = 1'b1; rsp_len = RLW'(3);
    step();
    rsp_commit = 1'b0;
    step();
    chk("R8 req_n pending idle", req_n, 0);

    // R4 receive steps
    dir_send = 1'b0; act_n = 1'b0;
    step();
    chk("R4 first byte", sr, 8'h11);
    chk("R11 rewind to first", req_n, 0);
    ack_n = 1'b0; step();
    chk("R4 second byte", sr, 8'h22);
    ack_n = 1'b1; step();
    chk("R4 third byte", sr, 8'h33);
    chk("R5 req_n released", req_n, 1);
    chk("R10 irq on load", sr_irq, 1);
    ack_n = 1'b0; step();
    chk("R4 empty step sr", sr, 8'h33);
    chk("R4 empty step irq", sr_irq, 0);
    act_n = 1'b1; step();
    chk("R7 empty packet no done", pkt_done, 0);
    chk("R7 empty packet irq", sr_irq, 1);
    ack_n = 1'b1; step();

    // R12 host write
    sr_wr = 1'b1; sr_wdata = 8'h5A; step(); sr_wr = 1'b0;
    chk("R12 sr write", sr, 8'h5A);

    // R3 capture overflow
    dir_send = 1'b1; act_n = 1'b0; step();
    ack_n = 1'b0; step();
    ack_n = 1'b1; step();
    ack_n = 1'b0; step();
    chk("R3 full count", cap_count, CAPD);
    ack_n = 1'b1; step();
    chk("R3 overflow count", cap_count, CAPD);
    chk("R3 overflow irq", sr_irq, 0);
    act_n = 1'b1; step();
    chk("R7 done after full", pkt_done, 1);
    chk("R7 len after full", pkt_len, CAPD);
    chk("R7 count cleared", cap_count, 0);
    step();

    // R9 delayed interrupt
    pdir_wr = 1'b1; pdir_wdata = 8'h00; step(); pdir_wr = 1'b0;
    chk("R9 pdir written", pdir, 8'h00);
    repeat (3) step();
    ack_n = 1'b0;
    measure_irq("R9 delay", DLY + 1);
    step();
    ack_n = 1'b1;
    begin
      int early = 0;
      for (int k = 1; k <= 10; k++) begin
        step();
        if (sr_irq) early = 1;
      end
      chk("R9 no early pulse", early, 0);
    end
    ack_n = 1'b0;
    measure_irq("R9 restart", DLY + 1);
    step();
    chk("R9 single pulse", sr_irq, 0);

    finish_run();
  end
endmodule